// File: doc/BRIEF.md
# Reset Cause Recorder with Guarded Software Reset

This block keeps a small set of sticky flags that tell software which reset sources have fired since the flags were last cleared. There is one flag for each of six sources: power-up, the external reset pin, supply droop, the watchdog, the debug/programming port and a software-initiated reset. Each source drives a single-cycle pulse input. Software reads the flags through a small register bus and clears them by writing ones. A power-up pulse is treated differently from the others. It discards every other recorded cause and leaves only its own flag set.

Software can also ask for a reset. It writes a one to a request bit in a control register, and the block then emits a single-cycle `sw_reset_req` pulse for an external reset generator to act on. The request bit is guarded. A write to it is honoured only inside a short unlock window, which opens when a fixed key byte is written to a separate unlock register. The request bit returns to zero as soon as any reset source pulse arrives, and that same pulse also closes any open unlock window.

Top module: `reset_cause_unit`

## Requirements
- R1: After the synchronous reset `rst`, all cause flags read zero, the control register reads zero, the unlock window is closed and `sw_reset_req` is low.
- R2: A pulse on `src_pulse[i]` sets cause flag i from the next cycle on. The bit map is: 0 power-up, 1 external pin, 2 supply droop, 3 watchdog, 4 debug port, 5 software. When bit 0 is not pulsed, flags that are already set stay set, and all sources pulsed in the same cycle are recorded together.
- R3: A bus write to address 0 clears every flag whose bit in `wdata[5:0]` is one. Flags whose bit is zero are unaffected.
- R4: A pulse on `src_pulse[0]` leaves the status register at exactly 0x01 in the next cycle, whatever the earlier flags were and whatever other sources pulse in the same cycle. The power-up flag is cleared only by a write of one.
- R5: When a source pulse and a clear write hit the same flag in the same cycle, the flag ends up set.
- R6: Reads of address 0 return zero in bits 7:6. Reads of address 1 return zero in bits 7:1. Reads of addresses 2 and 3 return zero. Writes to reserved bits change nothing that can be read.
- R7: An accepted write to address 1 loads the request bit from `wdata[0]`. If the value is one, `sw_reset_req` is high for exactly the next cycle and the bit then reads one until any source pulse clears it. A source pulse in the same cycle as the write wins: the bit stays zero and no request is made.
- R8: Writing the key 0xA5 to address 2 opens a window. Writes to address 1 at any of the 4 clock edges that follow the key write are accepted. Later writes, writes made with no key, and writes made after any other byte was written to address 2 are ignored.
- R9: Any source pulse closes an open unlock window, so a write to address 1 after that pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_pulse | input | 6 | One-cycle reset source pulses, bit map as in R2 |
| addr | input | 2 | Register address: 0 status, 1 control, 2 unlock |
| we | input | 1 | Write enable |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| sw_reset_req | output | 1 | One-cycle software reset request |

## Verification
The bench steps through all 64 source patterns, each applied in the same cycle as a changing clear mask. This catches a power-up pulse that fails to wipe the other flags or that lets a simultaneous source survive, and a clear that beats a set. A sweep over all 256 clear bytes shows up a flag that is cleared by a zero or left standing by a one, and a reserved bit that reads back non-zero. The unlock window is probed at every delay from zero to five idle cycles. A window that is one cycle too long or too short would accept or drop a write at the boundary. Further cases cover a wrong key, a source pulse arriving between the key and the write, and a source pulse in the same cycle as the write. A design that leaks a request in any of these cases would pulse `sw_reset_req` or leave the request bit reading one.

// File: rtl/rcause_pkg.sv
package rcause_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int NUM_SRC = 6;

    typedef logic [NUM_SRC-1:0] cause_vec_t;
    typedef logic [DATA_W-1:0]  byte_t;

    typedef enum int unsigned {
        SRC_POWERUP = 0,
        SRC_PIN     = 1,
        SRC_DROOP   = 2,
        SRC_WDOG    = 3,
        SRC_DEBUG   = 4,
        SRC_SOFT    = 5
    } src_idx_e;

    typedef enum logic [ADDR_W-1:0] {
        REG_STATUS = 2'd0,
        REG_CTRL   = 2'd1,
        REG_UNLOCK = 2'd2,
        REG_SPARE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     wr;
        reg_sel_e sel;
        byte_t    data;
    } bus_req_t;

    function automatic byte_t widen_cause(input cause_vec_t v);
        byte_t r;
        r = '0;
        r[NUM_SRC-1:0] = v;
        return r;
    endfunction

endpackage

// File: rtl/rcause_flags.sv
module rcause_flags
    import rcause_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cause_vec_t src,
    input  logic       clr_en,
    input  cause_vec_t clr_mask,
    output cause_vec_t flags
);

    cause_vec_t flags_q;
    cause_vec_t flags_d;
    logic       powerup;

    assign powerup = src[SRC_POWERUP];

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
            if (i == SRC_POWERUP) begin : g_pu
                always_comb begin
                    if (src[i])
                        flags_d[i] = 1'b1;
                    else if (clr_en && clr_mask[i])
                        flags_d[i] = 1'b0;
                    else
                        flags_d[i] = flags_q[i];
                end
            end else begin : g_other
                always_comb begin
                    if (powerup)
                        flags_d[i] = 1'b0;
                    else if (src[i])
                        flags_d[i] = 1'b1;
                    else if (clr_en && clr_mask[i])
                        flags_d[i] = 1'b0;
                    else
                        flags_d[i] = flags_q[i];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            flags_q <= '0;
        else
            flags_q <= flags_d;
    end

    assign flags = flags_q;

    AST_POWERUP_WIPES: assert property (@(posedge clk) disable iff (rst)
        powerup |=> (flags == cause_vec_t'(1)));  // R4
    AST_SOURCE_SETS: assert property (@(posedge clk) disable iff (rst)
        (!powerup && (|src)) |=> ((flags & $past(src)) == $past(src)));  // R5
    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (!powerup && !clr_en) |=> ((flags & $past(flags)) == $past(flags)));  // R2
    AST_CLEAR_ONES: assert property (@(posedge clk) disable iff (rst)
        (!powerup && clr_en) |=> ((flags & $past(clr_mask & ~src)) == '0));  // R3

endmodule

// File: rtl/rcause_unlock.sv
module rcause_unlock
    import rcause_pkg::*;
#(
    parameter int    WINDOW = 4,
    parameter byte_t KEY    = 8'hA5
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  key_wr,
    input  byte_t key_data,
    input  logic  issue,
    output logic  open
);

    localparam int CNT_W = $clog2(WINDOW + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WINDOW);

    logic [CNT_W-1:0] cnt_q;
    logic             key_ok;

    assign key_ok = key_wr && (key_data == KEY);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (issue)
            cnt_q <= '0;
        else if (key_ok)
            cnt_q <= CNT_FULL;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign open = (cnt_q != '0);

    AST_WIN_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_FULL);  // R8
    AST_KEY_OPENS: assert property (@(posedge clk) disable iff (rst)
        (key_ok && !issue) |=> open);  // R8
    AST_ISSUE_CLOSES: assert property (@(posedge clk) disable iff (rst)
        issue |=> !open);  // R9

endmodule

// File: rtl/rcause_ctrl.sv
module rcause_ctrl
    import rcause_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ctrl_wr,
    input  logic ctrl_bit_in,
    input  logic open,
    input  logic issue,
    output logic req_bit,
    output logic req_pulse
);

    logic accept;

    assign accept = ctrl_wr && open && !issue;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_bit   <= 1'b0;
            req_pulse <= 1'b0;
        end else begin
            req_pulse <= accept && ctrl_bit_in;
            if (issue)
                req_bit <= 1'b0;
            else if (accept)
                req_bit <= ctrl_bit_in;
        end
    end

    AST_PULSE_WITH_BIT: assert property (@(posedge clk) disable iff (rst)
        req_pulse |-> req_bit);  // R7
    AST_ISSUE_DROPS: assert property (@(posedge clk) disable iff (rst)
        issue |=> (!req_bit && !req_pulse));  // R7
    AST_LOCKED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!open && !issue) |=> ($stable(req_bit) && !req_pulse));  // R8

endmodule

// File: rtl/reset_cause_unit.sv
module reset_cause_unit
    import rcause_pkg::*;
#(
    parameter int    WINDOW = 4,
    parameter byte_t KEY    = 8'hA5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [5:0]  src_pulse,
    input  logic [1:0]  addr,
    input  logic        we,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        sw_reset_req
);

    bus_req_t   bus;
    cause_vec_t flags;
    logic       issue;
    logic       open;
    logic       req_bit;

    assign bus.wr   = we;
    assign bus.sel  = reg_sel_e'(addr);
    assign bus.data = wdata;

    assign issue = |src_pulse;

    rcause_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .src      (src_pulse),
        .clr_en   (bus.wr && (bus.sel == REG_STATUS)),
        .clr_mask (bus.data[NUM_SRC-1:0]),
        .flags    (flags)
    );

    rcause_unlock #(
        .WINDOW (WINDOW),
        .KEY    (KEY)
    ) u_unlock (
        .clk      (clk),
        .rst      (rst),
        .key_wr   (bus.wr && (bus.sel == REG_UNLOCK)),
        .key_data (bus.data),
        .issue    (issue),
        .open     (open)
    );

    rcause_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .ctrl_wr     (bus.wr && (bus.sel == REG_CTRL)),
        .ctrl_bit_in (bus.data[0]),
        .open        (open),
        .issue       (issue),
        .req_bit     (req_bit),
        .req_pulse   (sw_reset_req)
    );

    always_comb begin
        unique case (bus.sel)
            REG_STATUS: rdata = widen_cause(flags);
            REG_CTRL:   rdata = {{(DATA_W-1){1'b0}}, req_bit};
            default:    rdata = '0;
        endcase
    end

    AST_RSVD_STATUS: assert property (@(posedge clk) disable iff (rst)
        (bus.sel == REG_STATUS) |-> (rdata[7:6] == 2'b00));  // R6
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (sw_reset_req && !(we && (addr == REG_CTRL))) |=> !sw_reset_req);  // R7

endmodule

// File: tb/reset_cause_unit_bench.sv
module reset_cause_unit_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] src_pulse = '0;
    logic [1:0] addr = '0;
    logic       we = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       sw_reset_req;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    reset_cause_unit u_reset_cause_unit (
        .clk          (clk),
        .rst          (rst),
        .src_pulse    (src_pulse),
        .addr         (addr),
        .we           (we),
        .wdata        (wdata),
        .rdata        (rdata),
        .sw_reset_req (sw_reset_req)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic w, input logic [1:0] a, input logic [7:0] d,
                        input logic [5:0] s);
        we = w; addr = a; wdata = d; src_pulse = s;
        @(posedge clk);
        #1;
        we = 1'b0; wdata = '0; src_pulse = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [5:0] model;
        logic [7:0] clr;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(2'd0, v); check("R1 status", v, 8'h00);
        rd(2'd1, v); check("R1 ctrl", v, 8'h00);
        check("R1 req", {7'd0, sw_reset_req}, 8'h00);
        step(1'b1, 2'd1, 8'h01, 6'd0);
        rd(2'd1, v); check("R1 window closed", v, 8'h00);

        // R4 power-up alone
        step(1'b0, 2'd0, 8'h00, 6'b000001);
        rd(2'd0, v); check("R4 powerup", v, 8'h01);
        model = 6'b000001;

        // R2 R3 R4 R5 sweep of all source patterns with a changing clear mask
        for (int p = 0; p < 64; p++) begin
            clr = 8'((p * 29 + 7) & 8'hFF);
            step(1'b1, 2'd0, clr, 6'(p));
            if (p[0])
                model = 6'b000001;
            else
                model = (model & ~clr[5:0]) | 6'(p);
            rd(2'd0, v);
            if (p[0]) check("R4 sweep", v, {2'b00, model});
            else      check("R2 R3 R5 sweep", v, {2'b00, model});
        end

        // R3 R6 clear sweep over all 256 bytes
        for (int c = 0; c < 256; c++) begin
            step(1'b0, 2'd0, 8'h00, 6'b000001);
            step(1'b0, 2'd0, 8'h00, 6'b111110);
            step(1'b1, 2'd0, 8'(c), 6'd0);
            rd(2'd0, v);
            check("R3 R6 clear", v, {2'b00, 6'h3F & ~6'(c)});
        end

        // R4 power-up clears only others; power-up flag needs write of one
        step(1'b0, 2'd0, 8'h00, 6'b011110);
        step(1'b0, 2'd0, 8'h00, 6'b100001);
        rd(2'd0, v); check("R4 others wiped", v, 8'h01);
        step(1'b1, 2'd0, 8'h3E, 6'd0);
        rd(2'd0, v); check("R4 powerup kept", v, 8'h01);
        step(1'b1, 2'd0, 8'h01, 6'd0);
        rd(2'd0, v); check("R4 powerup cleared", v, 8'h00);

        // R8 no key
        step(1'b1, 2'd1, 8'h01, 6'd0);
        check("R8 no key req", {7'd0, sw_reset_req}, 8'h00);
        rd(2'd1, v); check("R8 no key bit", v, 8'h00);

        // R8 wrong key
        step(1'b1, 2'd2, 8'hA4, 6'd0);
        step(1'b1, 2'd1, 8'h01, 6'd0);
        rd(2'd1, v); check("R8 wrong key", v, 8'h00);

        // R8 R7 window boundary sweep
        for (int d = 0; d < 6; d++) begin
            step(1'b1, 2'd2, 8'hA5, 6'd0);
            for (int k = 0; k < d; k++) step(1'b0, 2'd0, 8'h00, 6'd0);
            step(1'b1, 2'd1, 8'hFF, 6'd0);
            check("R8 R7 req pulse", {7'd0, sw_reset_req}, (d <= 3) ? 8'h01 : 8'h00);
            rd(2'd1, v);
            check("R8 R6 ctrl read", v, (d <= 3) ? 8'h01 : 8'h00);
            step(1'b0, 2'd0, 8'h00, 6'd0);
            check("R7 pulse ends", {7'd0, sw_reset_req}, 8'h00);
            rd(2'd1, v);
            check("R7 bit held", v, (d <= 3) ? 8'h01 : 8'h00);
            step(1'b0, 2'd0, 8'h00, 6'b100000);
            rd(2'd1, v); check("R7 source clears bit", v, 8'h00);
        end

        // R9 source pulse closes window
        step(1'b1, 2'd2, 8'hA5, 6'd0);
        step(1'b0, 2'd0, 8'h00, 6'b001000);
        step(1'b1, 2'd1, 8'h01, 6'd0);
        check("R9 req", {7'd0, sw_reset_req}, 8'h00);
        rd(2'd1, v); check("R9 bit", v, 8'h00);

        // R7 source in same cycle as write wins
        step(1'b1, 2'd2, 8'hA5, 6'd0);
        step(1'b1, 2'd1, 8'h01, 6'b000010);
        check("R7 same cycle req", {7'd0, sw_reset_req}, 8'h00);
        rd(2'd1, v); check("R7 same cycle bit", v, 8'h00);

        // R6 unlock and spare addresses read zero
        rd(2'd2, v); check("R6 unlock read", v, 8'h00);
        rd(2'd3, v); check("R6 spare read", v, 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule